// File: doc/BRIEF.md
# Dual-Pair PWM Timer with Deadtime and Fault Shutdown

This block is a 16-bit counter-based timer with four channels arranged as two pairs. The counter advances on a prescaled clock and either wraps to zero at a programmable modulo or counts up and back down. Each channel can capture the count on a rising input edge, toggle its output on a compare match, or produce an edge-aligned PWM level. A pair can instead be joined so that its two compare values set the rising and falling edges of one waveform. The odd channel then carries the complement, and each output's rising edge is held back by a programmable deadtime.

Software programs the block through a simple write port. The modulo and compare values are double-buffered: the active copies change only at the counter's reload point, or at once while the counter is stopped. Any fault input drives every output low without waiting for a clock edge and latches a fault flag. A lock bit freezes the control, channel configuration and deadtime registers until reset. Event flags are cleared by writing ones, and the interrupt output is the OR of all flags.

Top module: `cpwm_timer`

## Requirements
- R1: The counter advances once every 2^P clocks, where P is CTRL[2:0] (address 0); with the counter disabled (CTRL[4]=0) it is held at 0.
- R2: In up mode (CTRL[3]=0) the count runs 0,1,...,MOD then returns to 0. The return sets the overflow flag, flags bit 4.
- R3: In up-down mode (CTRL[3]=1) the count runs from 0 up to MOD and back down to 0. The overflow flag is set only when the count leaves 0 going down-to-up, not at the top.
- R4: Writes to MOD (address 1) and to the compare values CV0..CV3 (addresses 2..5) take effect at the next reload point while the counter runs, and one clock later while it is disabled.
- R5: A channel in PWM mode (mode field 2 or 3 in CFG at address 6, bits [2i+1:2i]) outputs 1 while the count is below its compare value.
- R6: A channel in compare mode (mode 1) toggles its output on each prescaled step at which the count equals its compare value, and sets its channel flag (flags bit i).
- R7: A channel in capture mode (mode 0) copies the count into its capture word when its input rises. The edge passes a two-stage synchronizer, and the capture sets the channel flag.
- R8: With CFG bit 12+p set, pair p drives its even channel high while CV(2p) <= count < CV(2p+1) and its odd channel with the complement.
- R9: In a joined pair, each output rises only after its target has been high for DT (address 7) prescaled steps, so both outputs of a pair are never high together.
- R10: CFG bit 8+i inverts the output of channel i.
- R11: A high fault input forces all outputs low in the same cycle and sets flags bit 5. Outputs stay low until bit 5 is cleared while every fault input is low; a clear made while a fault is active is ignored.
- R12: Writing CTRL bit 7 locks the block. From then until reset, writes to CTRL, CFG and DT are ignored, while MOD and CV remain writable.
- R13: Writing ones to address 8 clears the matching flags, and irq_o is high exactly when a flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| cap_in | input | 4 | Capture inputs, one per channel |
| fault_in | input | 4 | Active-high fault inputs |
| pwm_o | output | 4 | Channel outputs |
| cnt_o | output | 16 | Current count |
| cap_o | output | 64 | Capture words, channel i in bits [16i+15:16i] |
| flags_o | output | 6 | Channel flags [3:0], overflow [4], fault [5] |
| irq_o | output | 1 | Any flag set |

## Verification
Faults in the counter or prescaler state show on cnt_o within one prescaled step, so the bench checks each transition against a model that tracks direction. A buffer that loads too early shows up within a period as a PWM edge at the wrong count or as a count that never reaches the old modulo. A deadtime counter in the wrong state shows as an output high at a count outside its expected window during a single steady-state period. A fault latch that releases too early shows on the first cycle after an ignored clear.

// File: rtl/cpwm_timer.sv
`timescale 1ns/1ps
module cpwm_timer #(
  parameter int CW   = 16,
  parameter int NCH  = 4,
  parameter int NFLT = 4,
  parameter int DTW  = 8,
  parameter int AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [NCH-1:0]    cap_in,
  input  logic [NFLT-1:0]   fault_in,
  output logic [NCH-1:0]    pwm_o,
  output logic [CW-1:0]     cnt_o,
  output logic [NCH*CW-1:0] cap_o,
  output logic [NCH+1:0]    flags_o,
  output logic              irq_o
);
  localparam int NP    = NCH / 2;
  localparam int PW    = 7;
  localparam int A_CTL = 0;
  localparam int A_MOD = 1;
  localparam int A_CV  = 2;
  localparam int A_CFG = A_CV + NCH;
  localparam int A_DT  = A_CFG + 1;
  localparam int A_CLR = A_DT + 1;
  localparam logic [CW-1:0] ONE = 1;

  logic [2:0]     psc;
  logic           updown, en, lock, dir_dn, ovf, fltf;
  logic [PW-1:0]  pcnt;
  logic [CW-1:0]  cnt, mod_b, mod_a;
  logic [CW-1:0]  cv_b [NCH];
  logic [CW-1:0]  cv_a [NCH];
  logic [CW-1:0]  cap  [NCH];
  logic [1:0]     mode [NCH];
  logic [DTW-1:0] dtc  [NCH];
  logic [DTW-1:0] dt;
  logic [NCH-1:0] pol, oc, s1, s2, chf, tgt, lvl, match, rise, chset;
  logic [NP-1:0]  comb;

  wire tick      = en && (pcnt >= ((PW'(1) << psc) - PW'(1)));
  wire boundary  = tick && (updown ? (dir_dn && cnt == '0) : (cnt >= mod_a));
  wire fault_any = |fault_in;
  wire wr_ctl    = wr_en && !lock;
  wire clr       = wr_en && wr_addr == AW'(A_CLR);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      match[i] = tick && cnt == cv_a[i];
      rise[i]  = s1[i] && !s2[i];
      chset[i] = (mode[i] == 2'd0) ? rise[i] : match[i];
      case (mode[i])
        2'd0:    tgt[i] = 1'b0;
        2'd1:    tgt[i] = oc[i];
        default: tgt[i] = cnt < cv_a[i];
      endcase
    end
    for (int p = 0; p < NP; p++)
      if (comb[p]) begin
        tgt[2*p]   = cnt >= cv_a[2*p] && cnt < cv_a[2*p+1];
        tgt[2*p+1] = !tgt[2*p];
      end
    for (int i = 0; i < NCH; i++)
      lvl[i] = tgt[i] && (!comb[i/2] || dtc[i] >= dt);
  end

  assign pwm_o   = (fltf || fault_any) ? '0 : (lvl ^ pol);
  assign cnt_o   = cnt;
  assign flags_o = {fltf, ovf, chf};
  assign irq_o   = |flags_o;

  for (genvar g = 0; g < NCH; g++) begin : g_cap
    assign cap_o[g*CW +: CW] = cap[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      psc <= '0; updown <= 1'b0; en <= 1'b0; lock <= 1'b0;
      dir_dn <= 1'b0; ovf <= 1'b0; fltf <= 1'b0;
      pcnt <= '0; cnt <= '0; mod_b <= '0; mod_a <= '0; dt <= '0;
      pol <= '0; oc <= '0; s1 <= '0; s2 <= '0; chf <= '0; comb <= '0;
      for (int i = 0; i < NCH; i++) begin
        cv_b[i] <= '0; cv_a[i] <= '0; cap[i] <= '0; mode[i] <= '0; dtc[i] <= '0;
      end
    end else begin
      if (wr_ctl && wr_addr == AW'(A_CTL)) begin
        psc    <= wr_data[2:0];
        updown <= wr_data[3];
        en     <= wr_data[4];
        lock   <= wr_data[7];
      end
      if (wr_en && wr_addr == AW'(A_MOD)) mod_b <= wr_data;
      if (wr_ctl && wr_addr == AW'(A_CFG)) begin
        for (int i = 0; i < NCH; i++) begin
          mode[i] <= wr_data[2*i +: 2];
          pol[i]  <= wr_data[2*NCH + i];
        end
        for (int p = 0; p < NP; p++) comb[p] <= wr_data[3*NCH + p];
      end
      if (wr_ctl && wr_addr == AW'(A_DT)) dt <= wr_data[DTW-1:0];

      pcnt <= (!en || tick) ? '0 : pcnt + PW'(1);
      if (!en) begin
        cnt <= '0; dir_dn <= 1'b0;
      end else if (tick) begin
        if (!updown) begin
          cnt <= (cnt >= mod_a) ? '0 : cnt + ONE;
          dir_dn <= 1'b0;
        end else if (!dir_dn) begin
          if (cnt >= mod_a) begin
            dir_dn <= 1'b1;
            cnt <= (cnt == '0) ? '0 : cnt - ONE;
          end else cnt <= cnt + ONE;
        end else if (cnt == '0) begin
          dir_dn <= 1'b0;
          cnt <= (mod_a == '0) ? '0 : ONE;
        end else cnt <= cnt - ONE;
      end

      if (!en || boundary) begin
        mod_a <= mod_b;
        for (int i = 0; i < NCH; i++) cv_a[i] <= cv_b[i];
      end
      ovf  <= boundary  || (ovf  && !(clr && wr_data[NCH]));
      fltf <= fault_any || (fltf && !(clr && wr_data[NCH+1]));

      s1 <= cap_in;
      s2 <= s1;
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && wr_addr == AW'(A_CV + i)) cv_b[i] <= wr_data;
        if (mode[i] == 2'd1 && match[i]) oc[i] <= !oc[i];
        if (mode[i] == 2'd0 && rise[i]) cap[i] <= cnt;
        chf[i] <= chset[i] || (chf[i] && !(clr && wr_data[i]));
        if (!tgt[i]) dtc[i] <= '0;
        else if (tick && dtc[i] < dt) dtc[i] <= dtc[i] + DTW'(1);
      end
    end
endmodule

module cpwm_timer_chk #(
  parameter int CW   = 16,
  parameter int NCH  = 4,
  parameter int NFLT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NFLT-1:0]   fault_in,
  input logic [NCH-1:0]    pwm_o,
  input logic [NCH+1:0]    flags_o,
  input logic [CW-1:0]     cnt_o,
  input logic [CW-1:0]     mod_a,
  input logic              tick,
  input logic              lock,
  input logic [NCH/2-1:0]  comb,
  input logic [NCH-1:0]    lvl
);
  a_r11_fault_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |-> (pwm_o == '0));
  a_r11_fault_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |=> flags_o[NCH+1]);
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= mod_a);
  a_r1_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt_o) || cnt_o == '0));
  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  for (genvar p = 0; p < NCH/2; p++) begin : g_pair
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      comb[p] |-> !(lvl[2*p] && lvl[2*p+1]));
  end
endmodule

bind cpwm_timer cpwm_timer_chk #(.CW(CW), .NCH(NCH), .NFLT(NFLT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .pwm_o(pwm_o), .flags_o(flags_o),
  .cnt_o(cnt_o), .mod_a(mod_a), .tick(tick), .lock(lock), .comb(comb), .lvl(lvl)
);

// File: tb/cpwm_timer_test.sv
`timescale 1ns/1ps
module cpwm_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, cap_in = '0, fault_in = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_o;
  logic [15:0] cnt_o;
  logic [63:0] cap_o;
  logic [5:0]  flags_o;
  logic        irq_o;

  cpwm_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_in(cap_in), .fault_in(fault_in), .pwm_o(pwm_o), .cnt_o(cnt_o), .cap_o(cap_o),
    .flags_o(flags_o), .irq_o(irq_o));

  always #2.5 clk = ~clk;

  typedef struct { string req; int kind; int idx; int exp; } item_t;
  item_t q[$];
  int tests = 0, fails = 0, meas = 0;
  bit done = 0;

  function automatic int actual(int kind, int idx);
    case (kind)
      0: return int'(pwm_o);
      1: return int'(flags_o);
      2: return int'(cnt_o);
      3: return int'(cap_o[idx*16 +: 16]);
      4: return int'(irq_o);
      5: return meas;
      default: return int'(flags_o[5]);
    endcase
  endfunction

  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      int a;
      it = q.pop_front();
      a = actual(it.kind, it.idx);
      tests++;
      if (a !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, a, it.exp);
      end
    end
  end

  task automatic push(string r, int k, int i, int e);
    item_t it;
    it.req = r; it.kind = k; it.idx = i; it.exp = e;
    q.push_back(it);
  endtask
  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    cyc();
    wr_en = 1'b0;
  endtask
  task automatic wait_cnt(int v);
    for (int n = 0; n < 300 && int'(cnt_o) != v; n++) cyc();
  endtask
  task automatic up_steps(string r, int m, int n);
    for (int k = 0; k < n; k++) begin
      int prev;
      prev = int'(cnt_o);
      cyc();
      push(r, 2, 0, prev >= m ? 0 : prev + 1);
    end
  endtask
  function automatic bit win(int c); return c >= 1 && c < 5; endfunction
  function automatic int comb_exp(int c, int dtv);
    int p;
    p = (c - dtv + 8) % 8;
    return {30'd0, !win(c) && !win(p), win(c) && win(p)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    push("R2 reset count", 2, 0, 0);
    push("R5 reset outputs", 0, 0, 0);
    push("R13 reset flags", 1, 0, 0);
    push("R13 reset irq", 4, 0, 0);

    // R2 up counting and overflow
    wr(1, 4); cyc();
    wr(0, 'h10);
    up_steps("R2 up step", 4, 20);
    wait_cnt(4); cyc();
    push("R2 overflow flag at wrap", 1, 0, 'h10);
    push("R13 irq follows flag", 4, 0, 1);
    wait_cnt(1); wr(8, 'h10);
    push("R13 flag cleared", 1, 0, 0);
    push("R13 irq low after clear", 4, 0, 0);

    // R1 prescaler divide by 4
    wr(0, 0); wr(0, 'h12);
    for (int rep = 0; rep < 2; rep++) begin
      int c, n;
      c = int'(cnt_o);
      for (int k = 0; k < 50 && int'(cnt_o) == c; k++) cyc();
      c = int'(cnt_o); n = 0;
      for (int k = 0; k < 50 && int'(cnt_o) == c; k++) begin cyc(); n++; end
      meas = n;
      push("R1 clocks per step", 5, 0, 4);
    end

    // R3 up-down
    wr(0, 0); wr(1, 3); cyc(); wr(8, 'h3f);
    wr(0, 'h18);
    wait_cnt(3);
    push("R3 no overflow at top", 1, 0, 0);
    cyc(); wait_cnt(0); cyc();
    push("R3 overflow at bottom", 1, 0, 'h10);
    begin
      bit d;
      d = 1'b0;
      for (int k = 0; k < 16; k++) begin
        int prev, e;
        prev = int'(cnt_o);
        if (!d) begin
          if (prev >= 3) begin d = 1'b1; e = prev - 1; end else e = prev + 1;
        end else begin
          if (prev == 0) begin d = 1'b0; e = 1; end else e = prev - 1;
        end
        cyc();
        push("R3 up-down step", 2, 0, e);
      end
    end

    // R5 edge PWM, R10 polarity
    wr(0, 0); wr(1, 7); wr(2, 3); wr(6, 'h0002); cyc();
    wr(0, 'h10);
    for (int k = 0; k < 16; k++) begin
      cyc(); push("R5 pwm below compare", 0, 0, int'(cnt_o) < 3 ? 1 : 0);
    end
    wr(6, 'h0102);
    for (int k = 0; k < 16; k++) begin
      cyc(); push("R10 inverted pwm", 0, 0, int'(cnt_o) < 3 ? 0 : 1);
    end

    // R4 buffered loads
    wr(6, 'h0002);
    wait_cnt(1); wr(2, 6);
    wait_cnt(5); push("R4 old compare kept", 0, 0, 0);
    wait_cnt(0); wait_cnt(5); push("R4 new compare after reload", 0, 0, 1);
    wait_cnt(1); wr(1, 3);
    wait_cnt(7); push("R4 old modulo kept", 2, 0, 7);
    cyc(); push("R4 wrap at old modulo", 2, 0, 0);
    up_steps("R4 new modulo", 3, 8);
    wr(0, 0); wr(2, 2); cyc(); wr(1, 7); cyc();
    wr(0, 'h10);
    wait_cnt(1); push("R4 immediate load when stopped", 0, 0, 1);
    wait_cnt(2); push("R4 immediate load when stopped", 0, 0, 0);

    // R6 compare toggle
    wr(0, 0); wr(3, 5); wr(6, 'h0004); wr(8, 'h3f); cyc();
    wr(0, 'h10);
    begin
      int o;
      wait_cnt(5); o = int'(pwm_o[1]);
      cyc();
      push("R6 toggle on match", 0, 0, (1 - o) << 1);
      push("R6 channel flag on match", 1, 0, 'h02);
      wait_cnt(5); push("R6 held until next match", 0, 0, (1 - o) << 1);
      cyc(); push("R6 toggle back", 0, 0, o << 1);
    end

    // R7 input capture
    wr(0, 0); wr(6, 0); wr(8, 'h3f); cyc();
    wr(0, 'h10);
    wait_cnt(2); cap_in[2] = 1'b1;
    cyc(); cyc();
    push("R7 capture value", 3, 2, 3);
    push("R7 capture flag", 1, 0, 'h04);
    cap_in[2] = 1'b0;
    wait_cnt(6); cap_in[2] = 1'b1;
    cyc(); cyc();
    push("R7 second capture", 3, 2, 7);
    cap_in[2] = 1'b0;

    // R8 joined pair, R9 deadtime
    wr(0, 0); wr(2, 1); wr(3, 5); wr(7, 0); wr(6, 'h1000); cyc();
    wr(0, 'h10);
    wait_cnt(7); cyc();
    for (int k = 0; k < 16; k++) begin
      cyc(); push("R8 joined pair window", 0, 0, comb_exp(int'(cnt_o), 0));
    end
    wr(7, 2);
    wait_cnt(7); cyc();
    for (int k = 0; k < 16; k++) begin
      cyc(); push("R9 deadtime delayed rise", 0, 0, comb_exp(int'(cnt_o), 2));
    end
    wr(7, 0);
    wait_cnt(7); cyc();

    // R11 fault shutdown
    wait_cnt(2);
    fault_in = 4'b0100;
    push("R11 immediate force low", 0, 0, 0);
    cyc(); push("R11 fault flag", 6, 0, 1);
    fault_in = 4'b0000;
    for (int k = 0; k < 4; k++) begin
      cyc(); push("R11 latched low", 0, 0, 0);
    end
    fault_in = 4'b0001;
    wr(8, 'h20);
    fault_in = 4'b0000;
    push("R11 clear ignored during fault", 6, 0, 1);
    cyc(); push("R11 still low", 0, 0, 0);
    wr(8, 'h20);
    push("R11 flag cleared", 6, 0, 0);
    for (int k = 0; k < 8; k++) begin
      push("R11 outputs resume", 0, 0, comb_exp(int'(cnt_o), 0));
      cyc();
    end

    // R12 lock
    wr(0, 'h90);
    wr(0, 'h00);
    up_steps("R12 control write ignored", 7, 10);
    wr(6, 'h0000); wr(7, 3);
    for (int k = 0; k < 10; k++) begin
      cyc(); push("R12 config and deadtime writes ignored", 0, 0, comb_exp(int'(cnt_o), 0));
    end

    cyc(); cyc();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule